// File: doc/BRIEF.md
# Strobed and Handshake Parallel Port

This block is an 8-bit parallel port controller that sits between a host register bus and a peripheral. The peripheral drives one strobe into the block (`stra`) and receives one strobe from it (`strb`). A port "C" carries data in either direction under a direction register. A separate output-only port "B" sends plain strobed output. The host reaches every register through a simple synchronous bus. A write or a read counts in the clock cycle where `bus_wr` or `bus_rd` is high. Read data is combinational from `bus_addr`.

In simple mode, each active `stra` edge captures the port C pins into an input latch and raises a status flag. The flag can also raise an interrupt. Each write to port B sends a two-cycle `strb` pulse. In handshake mode, the `strb` line takes on one of four roles, chosen by two control bits:
- an acknowledge pulse after each latch read;
- a level READY signal;
- a data-available pulse after each latch write;
- a data-available level that is held until the peripheral acknowledges on `stra`.

The register bus has no back-pressure: every access completes in the cycle it is presented.

Address map (3-bit `bus_addr`):
- 0: control (read/write)
- 1: port C latch (read returns the input latch; write loads the port C output register)
- 2: port B output
- 3: raw port C pins (read only)
- 4: port C direction

Control bits:
- bit0 `strb_hi`: 1 = `strb` active-high, 0 = active-low.
- bit1 `stra_rise`: 1 = rising `stra` edge is active, 0 = falling.
- bit2 pulsed: 1 = pulsed, 0 = interlocked.
- bit3 out_hs: 1 = output handshake, 0 = input handshake.
- bit4 hs_en: 1 = handshake mode, 0 = simple mode.
- bit6 irq_en: interrupt enable.
- bit7 flag: read-only.
- bit5: reads 0.

Top module: `ppt_port`

## Requirements
- R1: After reset, control, direction, port B output and port C output all read 0. `irq` is 0. `strb` is high, because active-low is the reset polarity and `strb` is inactive.
- R2: `stra` passes through a two-flop synchroniser. When `stra` changes in the active direction (falling with control bit1=0, rising with bit1=1), the port C pins are captured into the latch and the flag (control bit7) sets after the third rising clock edge, and not before. An edge in the other direction has no effect.
- R3: The flag clears only when a read of control (taken while the flag is set) is followed by a read of address 1. A read of address 1 alone leaves the flag set.
- R4: If a second active edge arrives before the clearing sequence, the latch takes the new pins and the flag stays set.
- R5: `irq` is high exactly while the flag is set and control bit6 is 1.
- R6: In simple mode, a write to address 2 appears on `pb_out` after the write edge, and `strb` is active for exactly 2 cycles.
- R7: Control bit0 selects the `strb` polarity: 1 = active-high, 0 = active-low.
- R8: Pulsed input handshake (bit4=1, bit3=0, bit2=1): each read of address 1 makes a 2-cycle `strb` pulse.
- R9: Interlocked input handshake (bit4=1, bit3=0, bit2=0): `strb` is active (ready) while the flag is clear and inactive while it is set.
- R10: Pulsed output handshake (bit4=1, bit3=1, bit2=1): a write to address 1 drives `pc_out` and makes a 2-cycle `strb` pulse.
- R11: Interlocked output handshake (bit4=1, bit3=1, bit2=0): a write to address 1 makes `strb` active. `strb` stays active until an active `stra` edge is detected, and goes inactive on the same edge that sets the flag.
- R12: Address 4 holds the direction (1 = output) and drives `pc_dir`. Address 3 reads the raw port C pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational from address) |
| pc_in | input | DATA_W | Port C pin levels |
| pc_out | output | DATA_W | Port C output register |
| pc_dir | output | DATA_W | Port C direction, 1 = drive |
| pb_out | output | DATA_W | Port B output register |
| stra | input | 1 | Strobe / acknowledge from the peripheral |
| strb | output | 1 | Strobe / ready / data-available to the peripheral |
| irq | output | 1 | Interrupt request |

## Verification
A flag stuck set or stuck clear shows on `irq` and on control bit7 within one cycle of the edge or read that should have changed it. The bench checks both the cycle before the expected change and the cycle of the change. A clear-arming bit in the wrong state shows when a bare latch read clears the flag, or when the full sequence fails to clear it. A wrong pulse counter or a wrong level term shows as a `strb` waveform that is off by a cycle, or stuck, within three cycles of the triggering access.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_CLATCH = 3'd1,
    A_BOUT   = 3'd2,
    A_CPINS  = 3'd3,
    A_CDIR   = 3'd4
  } reg_addr_e;

  localparam int CB_HI   = 0;
  localparam int CB_RISE = 1;
  localparam int CB_PLS  = 2;
  localparam int CB_OUT  = 3;
  localparam int CB_HS   = 4;
  localparam int CB_IRQ  = 6;
  localparam int CB_FLAG = 7;

  typedef struct packed {
    logic irq_en;
    logic hs_en;
    logic out_hs;
    logic pulsed;
    logic stra_rise;
    logic strb_hi;
  } port_ctrl_t;
endpackage

// File: rtl/ppt_edge_sync.sv
module ppt_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stra,
  input  logic rise_sel,
  output logic act_edge
);
  logic [SYNC_STAGES-1:0] sh;
  logic prev;
  logic cur;

  assign cur = sh[SYNC_STAGES-1];

  // flops rest high: the idle level of the strobe line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      prev <= 1'b1;
    end else begin
      sh   <= {sh[SYNC_STAGES-2:0], stra};
      prev <= cur;
    end
  end

  assign act_edge = rise_sel ? (cur & ~prev) : (~cur & prev);

  // R2: an active edge lasts one cycle unless the edge select moves
  assert_edge_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act_edge ##1 $stable(rise_sel) |-> !act_edge);
endmodule

// File: rtl/ppt_flag.sv
module ppt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic ctrl_rd,
  input  logic latch_rd,
  output logic flag
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (set_evt)
        flag <= 1'b1;
      else if (latch_rd && armed)
        flag <= 1'b0;

      if (latch_rd)
        armed <= 1'b0;
      else if (ctrl_rd && flag)
        armed <= 1'b1;
    end
  end

  assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);

  assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(armed && latch_rd));
endmodule

// File: rtl/ppt_strb_gen.sv
module ppt_strb_gen #(
  parameter int PULSE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_trig,
  input  logic hs_en,
  input  logic pulsed,
  input  logic out_hs,
  input  logic strb_hi,
  input  logic flag,
  input  logic avail_set,
  input  logic ack,
  output logic strb
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic pulse_on;
  logic avail;
  logic level_on;
  logic active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (pulse_trig)
      cnt <= CW'(PULSE_CYCLES);
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      avail <= 1'b0;
    else if (avail_set)
      avail <= 1'b1;
    else if (ack)
      avail <= 1'b0;
  end

  assign pulse_on = (cnt != '0);
  assign level_on = hs_en && !pulsed && (out_hs ? avail : !flag);
  assign active   = pulse_on || level_on;
  assign strb     = strb_hi ? active : !active;

  generate
    if (PULSE_CYCLES >= 2) begin : g_min_width
      assert_pulse_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_on) |=> pulse_on);
    end
  endgenerate

  assert_avail_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    avail && !ack |=> avail);
endmodule

// File: rtl/ppt_port.sv
module ppt_port
  import ppt_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int PULSE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pc_in,
  output logic [DATA_W-1:0] pc_out,
  output logic [DATA_W-1:0] pc_dir,
  output logic [DATA_W-1:0] pb_out,
  input  logic              stra,
  output logic              strb,
  output logic              irq
);
  port_ctrl_t ctrl;
  logic [DATA_W-1:0] c_latch;
  logic act_edge;
  logic flag;

  logic wr_ctrl, wr_clatch, wr_bout, wr_cdir;
  logic rd_ctrl, rd_clatch;
  logic pulse_trig;

  assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
  assign wr_clatch = bus_wr && (bus_addr == A_CLATCH);
  assign wr_bout   = bus_wr && (bus_addr == A_BOUT);
  assign wr_cdir   = bus_wr && (bus_addr == A_CDIR);
  assign rd_ctrl   = bus_rd && (bus_addr == A_CTRL);
  assign rd_clatch = bus_rd && (bus_addr == A_CLATCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      pc_dir <= '0;
      pc_out <= '0;
      pb_out <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl.strb_hi   <= bus_wdata[CB_HI];
        ctrl.stra_rise <= bus_wdata[CB_RISE];
        ctrl.pulsed    <= bus_wdata[CB_PLS];
        ctrl.out_hs    <= bus_wdata[CB_OUT];
        ctrl.hs_en     <= bus_wdata[CB_HS];
        ctrl.irq_en    <= bus_wdata[CB_IRQ];
      end
      if (wr_cdir)   pc_dir <= bus_wdata;
      if (wr_clatch) pc_out <= bus_wdata;
      if (wr_bout)   pb_out <= bus_wdata;
    end
  end

  // input latch; in output handshake the strobe is only an acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      c_latch <= '0;
    else if (act_edge && !(ctrl.hs_en && ctrl.out_hs))
      c_latch <= pc_in;
  end

  ppt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .stra     (stra),
    .rise_sel (ctrl.stra_rise),
    .act_edge (act_edge)
  );

  ppt_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (act_edge),
    .ctrl_rd  (rd_ctrl),
    .latch_rd (rd_clatch),
    .flag     (flag)
  );

  always_comb begin
    pulse_trig = 1'b0;
    if (!ctrl.hs_en)
      pulse_trig = wr_bout;
    else if (ctrl.pulsed)
      pulse_trig = ctrl.out_hs ? wr_clatch : rd_clatch;
  end

  ppt_strb_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_strb (
    .clk        (clk),
    .rst_n      (rst_n),
    .pulse_trig (pulse_trig),
    .hs_en      (ctrl.hs_en),
    .pulsed     (ctrl.pulsed),
    .out_hs     (ctrl.out_hs),
    .strb_hi    (ctrl.strb_hi),
    .flag       (flag),
    .avail_set  (wr_clatch && ctrl.hs_en && ctrl.out_hs && !ctrl.pulsed),
    .ack        (act_edge),
    .strb       (strb)
  );

  assign irq = flag && ctrl.irq_en;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[CB_HI]   = ctrl.strb_hi;
        bus_rdata[CB_RISE] = ctrl.stra_rise;
        bus_rdata[CB_PLS]  = ctrl.pulsed;
        bus_rdata[CB_OUT]  = ctrl.out_hs;
        bus_rdata[CB_HS]   = ctrl.hs_en;
        bus_rdata[CB_IRQ]  = ctrl.irq_en;
        bus_rdata[CB_FLAG] = flag;
      end
      A_CLATCH: bus_rdata = c_latch;
      A_BOUT:   bus_rdata = pb_out;
      A_CPINS:  bus_rdata = pc_in;
      A_CDIR:   bus_rdata = pc_dir;
      default:  bus_rdata = '0;
    endcase
  end

  assert_bout_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bout |=> pb_out == $past(bus_wdata));

  assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(act_edge) || $past(wr_ctrl));
endmodule

// File: tb/test_ppt_port.sv
module test_ppt_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pc_in = '0;
  logic [7:0] pc_out, pc_dir, pb_out;
  logic       stra = 1'b1;
  logic       strb, irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ppt_port i_ppt_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pc_in(pc_in), .pc_out(pc_out),
    .pc_dir(pc_dir), .pb_out(pb_out), .stra(stra), .strb(strb), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    stra = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; rst_n = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // falling strobe with given pins, then back high after the flag shows
  task automatic strobe_in(input logic [7:0] pins);
    @(negedge clk);
    pc_in = pins; stra = 1'b0;
    wait_n(3);
    stra = 1'b1;
    wait_n(3);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    bus_read(3'd0, d); check("R1 ctrl", d, 8'h00);
    bus_read(3'd4, d); check("R1 dir", d, 8'h00);
    check("R1 pb_out", pb_out, 8'h00);
    check("R1 pc_out", pc_out, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 strb", {7'd0, strb}, 8'h01);
  endtask

  task automatic t_strobe_falling();
    logic [7:0] d;
    do_reset();
    bus_write(3'd0, 8'h40);
    @(negedge clk);
    pc_in = 8'hA5; stra = 1'b0;
    wait_n(2); check("R2 flag not before third edge", {7'd0, irq}, 8'h00);
    wait_n(1); check("R2 flag after third edge", {7'd0, irq}, 8'h01);
    bus_read(3'd1, d); check("R2 latched pins", d, 8'hA5);
    check("R3 bare latch read keeps flag", {7'd0, irq}, 8'h01);
    bus_read(3'd0, d); check("R3 ctrl flag bit", d, 8'hC0);
    bus_read(3'd1, d);
    check("R3 flag cleared by sequence", {7'd0, irq}, 8'h00);
    stra = 1'b1;
    wait_n(4); check("R2 rising ignored in falling mode", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_rising();
    logic [7:0] d;
    do_reset();
    bus_write(3'd0, 8'h42);
    @(negedge clk);
    pc_in = 8'h3E; stra = 1'b0;
    wait_n(4); check("R2 falling ignored in rising mode", {7'd0, irq}, 8'h00);
    stra = 1'b1;
    wait_n(3); check("R2 rising edge sets flag", {7'd0, irq}, 8'h01);
    bus_read(3'd1, d); check("R2 rising latch", d, 8'h3E);
  endtask

  task automatic t_overwrite();
    logic [7:0] d;
    do_reset();
    strobe_in(8'h11);
    strobe_in(8'h22);
    bus_read(3'd0, d); check("R4 flag still set", d, 8'h80);
    bus_read(3'd1, d); check("R4 latch overwritten", d, 8'h22);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    do_reset();
    strobe_in(8'h05);
    check("R5 irq masked", {7'd0, irq}, 8'h00);
    bus_write(3'd0, 8'h40);
    check("R5 irq enabled with flag", {7'd0, irq}, 8'h01);
    bus_write(3'd0, 8'h00);
    check("R5 irq masked again", {7'd0, irq}, 8'h00);
    bus_read(3'd0, d); check("R5 flag kept", d, 8'h80);
  endtask

  task automatic t_simple_out();
    do_reset();
    bus_write(3'd2, 8'h5A);
    check("R6 pb_out", pb_out, 8'h5A);
    check("R6 strb low 1", {7'd0, strb}, 8'h00);
    wait_n(1); check("R6 strb low 2", {7'd0, strb}, 8'h00);
    wait_n(1); check("R6 strb ends", {7'd0, strb}, 8'h01);
    bus_write(3'd0, 8'h01);
    check("R7 idle low when active-high", {7'd0, strb}, 8'h00);
    bus_write(3'd2, 8'hA6);
    check("R7 strb high 1", {7'd0, strb}, 8'h01);
    wait_n(1); check("R7 strb high 2", {7'd0, strb}, 8'h01);
    wait_n(1); check("R7 strb ends", {7'd0, strb}, 8'h00);
  endtask

  task automatic t_pulsed_in();
    logic [7:0] d;
    do_reset();
    bus_write(3'd0, 8'h14);
    strobe_in(8'h3C);
    check("R8 strb idle", {7'd0, strb}, 8'h01);
    bus_read(3'd0, d);
    check("R8 ctrl read no pulse", {7'd0, strb}, 8'h01);
    bus_read(3'd1, d);
    check("R8 latch data", d, 8'h3C);
    check("R8 ack 1", {7'd0, strb}, 8'h00);
    wait_n(1); check("R8 ack 2", {7'd0, strb}, 8'h00);
    wait_n(1); check("R8 ack ends", {7'd0, strb}, 8'h01);
  endtask

  task automatic t_interlocked_in();
    logic [7:0] d;
    do_reset();
    bus_write(3'd0, 8'h10);
    check("R9 ready while empty", {7'd0, strb}, 8'h00);
    @(negedge clk);
    pc_in = 8'h77; stra = 1'b0;
    wait_n(2); check("R9 still ready", {7'd0, strb}, 8'h00);
    wait_n(1); check("R9 not ready when full", {7'd0, strb}, 8'h01);
    stra = 1'b1;
    bus_read(3'd0, d);
    check("R9 ctrl read keeps not ready", {7'd0, strb}, 8'h01);
    bus_read(3'd1, d);
    check("R9 ready after clear", {7'd0, strb}, 8'h00);
  endtask

  task automatic t_pulsed_out();
    do_reset();
    bus_write(3'd0, 8'h1C);
    bus_write(3'd1, 8'hC3);
    check("R10 pc_out", pc_out, 8'hC3);
    check("R10 strb 1", {7'd0, strb}, 8'h00);
    wait_n(1); check("R10 strb 2", {7'd0, strb}, 8'h00);
    wait_n(1); check("R10 strb ends", {7'd0, strb}, 8'h01);
  endtask

  task automatic t_interlocked_out();
    do_reset();
    bus_write(3'd0, 8'h18);
    check("R11 idle", {7'd0, strb}, 8'h01);
    bus_write(3'd1, 8'h81);
    check("R11 pc_out", pc_out, 8'h81);
    check("R11 avail", {7'd0, strb}, 8'h00);
    wait_n(4); check("R11 held", {7'd0, strb}, 8'h00);
    stra = 1'b0;
    wait_n(2); check("R11 held until ack", {7'd0, strb}, 8'h00);
    wait_n(1); check("R11 released by ack", {7'd0, strb}, 8'h01);
    stra = 1'b1;
  endtask

  task automatic t_dir();
    logic [7:0] d;
    do_reset();
    bus_write(3'd4, 8'hF0);
    bus_read(3'd4, d); check("R12 dir read", d, 8'hF0);
    check("R12 pc_dir", pc_dir, 8'hF0);
    pc_in = 8'h96;
    bus_read(3'd3, d); check("R12 raw pins", d, 8'h96);
  endtask

  initial begin
    t_reset();
    t_strobe_falling();
    t_rising();
    t_overwrite();
    t_irq();
    t_simple_out();
    t_pulsed_in();
    t_interlocked_in();
    t_pulsed_out();
    t_interlocked_out();
    t_dir();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule